// File: doc/BRIEF.md
# Security code validation unit

This unit decides whether a secret code, presented one bit at a time, matches a reference held in cells that model non-volatile storage. The caller shifts the candidate in most significant bit first and then pulses a strobe. The unit compares the bits as they arrive. It does not buffer the whole candidate: a single match flag drops at the first wrong bit. The strobe ends the presentation, and the verdict goes to a session flag. That flag opens either the issuer's path, while the part is still being personalized, or the application path, once personalization is complete.

Every failed presentation programs one more cell of a thermometer tally. The tally is not cleared by reset, so failures add up across power cycles. When the fourth consecutive failure is recorded, the unit locks permanently and accepts no further presentation. A successful presentation made before that point erases the tally. The reset input stands for power-on and supply-drop detection. It clears the session flag and any half-shifted candidate, but it leaves the tally cells untouched.

Top module: `sec_code_unit`

## Requirements
- R1: With `bitValid` high, each clock edge shifts one candidate bit from `bitIn`, most significant bit first. A `present` pulse after exactly 16 bits that all equal the reference code (default 16'hA5C3) sets `codeValid` at that same edge.
- R2: A presentation fails and clears `codeValid` in any of three cases: any bit differs from the reference, fewer than 16 bits were shifted, or more than 16 bits were shifted.
- R3: Each failed presentation adds one to the failure tally. The fourth failure in a row raises `locked` at the edge that evaluates it.
- R4: A successful presentation made while unlocked erases the tally. Three failures, then a pass, then three more failures therefore leave `locked` low.
- R5: While `locked` is high, shifted bits and `present` pulses have no effect. `codeValid` stays 0 and `locked` stays 1 for good.
- R6: Driving `rstN` low clears `codeValid` and any partly shifted candidate. The tally and `locked` survive it, so failures made before and after a reset count as consecutive.
- R7: `issuerOpen` is `codeValid` AND NOT `personalized`. `appOpen` is `codeValid` AND `personalized`. Both follow the `personalized` input combinationally.
- R8: A bit offered in the same cycle as `present` is discarded. Each `present` pulse starts the next presentation from an empty shift state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on / supply-drop reset |
| bitValid | input | 1 | Qualifies `bitIn` for shifting |
| bitIn | input | 1 | Serial candidate bit, most significant bit first |
| present | input | 1 | Ends a presentation and requests the verdict |
| personalized | input | 1 | High once personalization is complete |
| codeValid | output | 1 | Session flag: last presentation matched |
| locked | output | 1 | Permanent lock after four consecutive failures |
| issuerOpen | output | 1 | Issuer access grant (before personalization) |
| appOpen | output | 1 | Application access grant (after personalization) |

## Verification
The assertions assume two things about the inputs. First, `present` is a single-cycle pulse. Second, the tally cells start erased, as the non-volatile cells would on a fresh part. The stimulus drives every input on the falling clock edge and never holds `present` for more than one cycle. Because the tally is never reset, the bench arranges its tests so that the number of failures is known at each point: every group that could approach the limit ends with a correct presentation, until the final sequence deliberately crosses the limit, partly on each side of a reset.

// File: rtl/sec_code_pkg.sv
package sec_code_pkg;

  // Strobes from the control to the shift datapath
  typedef struct packed {
    logic shiftEn;   // accept one candidate bit this cycle
    logic seqClear;  // presentation ended: restart shift state
  } seqCtrl_t;

endpackage

// File: rtl/sec_code_shift.sv
module sec_code_shift
  import sec_code_pkg::*;
#(
  parameter int              CODE_W   = 16,
  parameter logic [CODE_W-1:0] REF_CODE = 16'hA5C3
) (
  input  logic     clk,
  input  logic     rstN,
  input  seqCtrl_t ctrl,
  input  logic     bitIn,
  output logic     seqPass
);

  localparam int CNT_W = $clog2(CODE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CODE_W);

  logic [CNT_W-1:0]  bitCount;
  logic              matchOk;
  logic [CODE_W-1:0] expectReg;   // reference, consumed from the top bit down

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount  <= '0;
      matchOk   <= 1'b1;
      expectReg <= REF_CODE;
    end else if (ctrl.seqClear) begin
      bitCount  <= '0;
      matchOk   <= 1'b1;
      expectReg <= REF_CODE;
    end else if (ctrl.shiftEn) begin
      if (bitCount == FULL_CNT) begin
        matchOk <= 1'b0;            // overrun: too many bits
      end else begin
        if (bitIn != expectReg[CODE_W-1]) matchOk <= 1'b0;
        expectReg <= {expectReg[CODE_W-2:0], 1'b0};
        bitCount  <= bitCount + 1'b1;
      end
    end
  end

  assign seqPass = matchOk && (bitCount == FULL_CNT);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= FULL_CNT);

  // R8
  seq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.seqClear |=> (bitCount == '0 && matchOk));

endmodule

// File: rtl/sec_code_ctrl.sv
module sec_code_ctrl
  import sec_code_pkg::*;
#(
  parameter int FAIL_LIMIT = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitValid,
  input  logic     present,
  input  logic     seqPass,
  output seqCtrl_t ctrl,
  output logic     codeValid,
  output logic     locked
);

  // Thermometer tally standing in for non-volatile cells: erased at
  // manufacture, never touched by the supply reset.
  logic [FAIL_LIMIT-1:0] failCells = '0;
  logic                  evalNow;

  assign locked  = failCells[FAIL_LIMIT-1];
  assign evalNow = present && !locked;

  assign ctrl.shiftEn  = bitValid && !present && !locked;
  assign ctrl.seqClear = present;

  always_ff @(posedge clk) begin
    if (evalNow) begin
      if (seqPass) failCells <= '0;
      else         failCells <= {failCells[FAIL_LIMIT-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        codeValid <= 1'b0;
    else if (evalNow) codeValid <= seqPass;
  end

  // R3
  fail_therm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failCells & (failCells + 1'b1)) == '0);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(locked) |-> locked);

  // R5
  lock_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !codeValid);

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !$past(codeValid)) |-> $past(present));

  // R4
  pass_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (present && !locked && seqPass) |=> (failCells == '0));

endmodule

// File: rtl/sec_code_unit.sv
module sec_code_unit #(
  parameter int                CODE_W     = 16,
  parameter logic [CODE_W-1:0] REF_CODE   = 16'hA5C3,
  parameter int                FAIL_LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic bitIn,
  input  logic present,
  input  logic personalized,
  output logic codeValid,
  output logic locked,
  output logic issuerOpen,
  output logic appOpen
);

  sec_code_pkg::seqCtrl_t ctrl;
  logic seqPass;

  sec_code_ctrl #(.FAIL_LIMIT(FAIL_LIMIT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitValid  (bitValid),
    .present   (present),
    .seqPass   (seqPass),
    .ctrl      (ctrl),
    .codeValid (codeValid),
    .locked    (locked)
  );

  sec_code_shift #(.CODE_W(CODE_W), .REF_CODE(REF_CODE)) u_shift (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .bitIn   (bitIn),
    .seqPass (seqPass)
  );

  // R7: grant routing by personalization state
  assign issuerOpen = codeValid && !personalized;
  assign appOpen    = codeValid &&  personalized;

endmodule

// File: tb/sec_code_unit_tb.sv
module sec_code_unit_tb;

  localparam logic [15:0] REF = 16'hA5C3;
  localparam int NVEC = 7;
  // entry: [22:7] code, [6:2] bit count, [1] personalized, [0] expected codeValid
  localparam logic [22:0] VEC [NVEC] = '{
    {REF,             5'd16, 1'b0, 1'b1},  // pass, issuer path
    {REF ^ 16'h0001,  5'd16, 1'b0, 1'b0},  // last bit wrong (fail 1)
    {REF,             5'd16, 1'b1, 1'b1},  // pass, app path, tally erased
    {REF ^ 16'h8000,  5'd16, 1'b1, 1'b0},  // first bit wrong (fail 1)
    {REF,             5'd15, 1'b0, 1'b0},  // short (fail 2)
    {REF,             5'd17, 1'b1, 1'b0},  // long (fail 3)
    {REF,             5'd16, 1'b1, 1'b1}   // pass, tally erased
  };

  logic clk = 0, rstN = 0, bitValid = 0, bitIn = 0, present = 0, personalized = 0;
  logic codeValid, locked, issuerOpen, appOpen;
  int checks = 0, fails = 0;
  bit finished = 0;

  sec_code_unit u_dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .present(present), .personalized(personalized),
    .codeValid(codeValid), .locked(locked),
    .issuerOpen(issuerOpen), .appOpen(appOpen)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic sendCode(logic [15:0] code, int nbits, bit merge);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bitValid = 1;
      bitIn = (i < 16) ? code[15-i] : 1'b0;
      if (merge && i == nbits - 1) present = 1;
    end
    @(negedge clk);
    if (!merge) begin
      bitValid = 0;
      present = 1;
      @(negedge clk);
    end
    bitValid = 0;
    present = 0;
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // reset state (R6, R7)
    chk("R6 reset codeValid", codeValid, 1'b0);
    chk("R6 reset locked", locked, 1'b0);
    chk("R7 reset issuerOpen", issuerOpen, 1'b0);
    chk("R7 reset appOpen", appOpen, 1'b0);
    @(negedge clk); rstN = 1;

    // vector table (R1, R2, R4, R7, R8)
    for (int v = 0; v < NVEC; v++) begin
      personalized = VEC[v][1];
      sendCode(VEC[v][22:7], int'(VEC[v][6:2]), 1'b0);
      chk("R1/R2/R8 table codeValid", codeValid, VEC[v][0]);
      chk("R3/R4 table locked", locked, 1'b0);
      chk("R7 table issuerOpen", issuerOpen, VEC[v][0] & ~VEC[v][1]);
      chk("R7 table appOpen", appOpen, VEC[v][0] & VEC[v][1]);
    end

    // R6: partial shift discarded by reset
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bitValid = 1; bitIn = REF[15-i];
    end
    @(negedge clk); bitValid = 0;
    pulseReset();
    personalized = 0;
    sendCode(REF, 16, 1'b0);
    chk("R6 fresh after partial", codeValid, 1'b1);

    // R7: grants follow personalized combinationally
    personalized = 1; #1;
    chk("R7 toggle appOpen", appOpen, 1'b1);
    chk("R7 toggle issuerOpen", issuerOpen, 1'b0);
    personalized = 0; #1;
    chk("R7 toggle back issuerOpen", issuerOpen, 1'b1);

    // R6: supply drop clears session flag
    pulseReset();
    chk("R6 drop codeValid", codeValid, 1'b0);
    chk("R6 drop issuerOpen", issuerOpen, 1'b0);

    // R8: last bit merged with strobe is discarded -> fail
    sendCode(REF, 16, 1'b1);
    chk("R8 merged bit discarded", codeValid, 1'b0);
    sendCode(REF, 16, 1'b0);
    chk("R8 next presentation fresh", codeValid, 1'b1);

    // R3/R6: three failures, reset, one more -> lock
    for (int k = 0; k < 3; k++) sendCode(REF ^ 16'h0100, 16, 1'b0);
    chk("R3 three fails unlocked", locked, 1'b0);
    chk("R2 fail clears codeValid", codeValid, 1'b0);
    pulseReset();
    chk("R6 tally kept, still unlocked", locked, 1'b0);
    sendCode(REF ^ 16'h0100, 16, 1'b0);
    chk("R3 fourth consecutive fail locks", locked, 1'b1);

    // R5: locked ignores correct code
    sendCode(REF, 16, 1'b0);
    chk("R5 locked codeValid", codeValid, 1'b0);
    chk("R5 locked stays", locked, 1'b1);
    personalized = 1; #1;
    chk("R5 locked appOpen", appOpen, 1'b0);

    // R6: lock survives reset
    pulseReset();
    chk("R6 lock survives reset", locked, 1'b1);
    sendCode(REF, 16, 1'b0);
    chk("R5 still rejected after reset", codeValid, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule